// File: doc/BRIEF.md
# Frame-Phase Stuff Decision Unit

This block decides, once per transmit frame, whether the outgoing line frame carries four stuff bits or none. It measures how far the start of a line-side 6 ms transmit frame lags the start of the PCM-side 6 ms transmit frame. The lag is counted in ticks of a general-purpose clock enable (`gclk_tick`). Measurement begins on a PCM frame-start pulse and ends on the next line frame-start pulse.

The measured lag is compared with two programmable thresholds. A short lag, below the nominal threshold, means the line side is running ahead, so four stuff bits are inserted. A lag at or above the nominal threshold means no stuff bits. A lag that reaches the maximum threshold also raises a sticky stuffing-error flag, which software clears with a pulse. One insertion absorbs 4 line bits of phase. The thresholds are normally programmed to the equivalent of 16 or 24 line bits. The values of the inserted bits come from a 4-bit stuff-value input.

Top module: `fp_stuff_unit`

## Requirements
- R1: After synchronous reset, `stuff_insert`, `stuff_count`, `stuff_bits`, `phase_count`, `decision_strobe` and `stuff_err` are all zero.
- R2: `phase_count` equals the number of cycles with `gclk_tick` high that lie strictly after the cycle that starts the measurement and strictly before the `hdsl_sof` cycle that ends it. The count saturates at 2^CNT_W-1 (4095 by default).
- R3: `stuff_count` only ever takes the values 0 or 4. It is 4 exactly when `stuff_insert` is 1.
- R4: `stuff_insert` is 1 when the measured count is below the nominal threshold. It is 0 when the count is equal to or above it.
- R5: When inserting, `stuff_bits` equals `stuff_value` as sampled in the `hdsl_sof` cycle. When not inserting, it is 0000.
- R6: All results appear one cycle after the `hdsl_sof` cycle, with `decision_strobe` high for that one cycle. They then hold until the next decision. An `hdsl_sof` with no measurement running changes nothing.
- R7: A measured count equal to or above the maximum threshold sets `stuff_err` in the same cycle that the results appear.
- R8: `stuff_err` stays set until an `err_clear` pulse arrives.
- R9: `err_clear` with no new error clears `stuff_err` on the next cycle. `err_clear` in the same cycle as a new error leaves `stuff_err` set.
- R10: Both thresholds are sampled in the `pcm_sof` cycle only. A threshold change during a measurement has no effect on that measurement.
- R11: A `pcm_sof` during a running measurement restarts it with a zero count. If `hdsl_sof` arrives in that same cycle, it first completes the old measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gclk_tick | input | 1 | Quantizing clock enable, one pulse per GCLK period |
| pcm_sof | input | 1 | PCM transmit frame-start pulse |
| hdsl_sof | input | 1 | Line transmit frame-start pulse |
| thr_nominal | input | CNT_W | Nominal threshold in ticks |
| thr_maximum | input | CNT_W | Maximum threshold in ticks |
| stuff_value | input | SV_W | Values for the inserted stuff bits |
| err_clear | input | 1 | Pulse that clears the stuffing error flag |
| stuff_insert | output | 1 | 1 = next frame carries stuff bits |
| stuff_count | output | 3 | Number of stuff bits for the next frame (0 or 4) |
| stuff_bits | output | SV_W | Stuff bit values for the next frame |
| phase_count | output | CNT_W | Last measured lag in ticks |
| decision_strobe | output | 1 | One-cycle pulse when new results appear |
| stuff_err | output | 1 | Sticky stuffing error flag |

## Verification
Every result is due exactly one clock edge after the `hdsl_sof` cycle. That covers the count, the insert decision, the stuff bits, the strobe and the error flag. A clear pulse shows on the flag one edge after it is sampled. The bench drives inputs on falling edges and reads outputs at the falling edge that follows the `hdsl_sof` rising edge. It then checks one falling edge later that the strobe has dropped while the decision holds. Expected counts come from the ticks the bench itself placed between the two frame-start pulses. Expected decisions and error values are computed from the thresholds the bench drove at `pcm_sof`.

// File: rtl/fp_stuff_pkg.sv
package fp_stuff_pkg;

    localparam int STUFF_PER_FRAME = 4;
    localparam int STUFF_CNT_W     = 3;

    typedef enum logic [0:0] {
        MEAS_IDLE = 1'b0,
        MEAS_RUN  = 1'b1
    } meas_state_e;

    typedef struct packed {
        logic insert;
        logic over_max;
    } verdict_t;

    function automatic logic [STUFF_CNT_W-1:0] stuff_count_of(input logic insert);
        return insert ? STUFF_CNT_W'(STUFF_PER_FRAME) : '0;
    endfunction

endpackage

// File: rtl/fp_phase_counter.sv
module fp_phase_counter
    import fp_stuff_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             start,
    input  logic             stop,
    output logic [CNT_W-1:0] count,
    output logic             done
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    meas_state_e state_q;
    logic [CNT_W-1:0] cnt_q;

    assign done  = stop && (state_q == MEAS_RUN);
    assign count = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MEAS_IDLE;
            cnt_q   <= '0;
        end else if (start) begin
            state_q <= MEAS_RUN;
            cnt_q   <= '0;
        end else if (done) begin
            state_q <= MEAS_IDLE;
        end else if (state_q == MEAS_RUN && tick && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/fp_threshold_latch.sv
module fp_threshold_latch #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] nom_in,
    input  logic [CNT_W-1:0] max_in,
    output logic [CNT_W-1:0] nom_q,
    output logic [CNT_W-1:0] max_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            nom_q <= '0;
            max_q <= '0;
        end else if (load) begin
            nom_q <= nom_in;
            max_q <= max_in;
        end
    end
endmodule

// File: rtl/fp_decision.sv
module fp_decision
    import fp_stuff_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int SV_W  = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   done,
    input  logic [CNT_W-1:0]       count,
    input  logic [CNT_W-1:0]       nom_q,
    input  logic [CNT_W-1:0]       max_q,
    input  logic [SV_W-1:0]        value,
    output logic                   insert,
    output logic [STUFF_CNT_W-1:0] nbits,
    output logic [SV_W-1:0]        bits,
    output logic [CNT_W-1:0]       count_q,
    output logic                   strobe,
    output logic                   err_set
);
    verdict_t v;

    always_comb begin
        v.insert   = (count < nom_q);
        v.over_max = (count >= max_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            insert  <= 1'b0;
            nbits   <= '0;
            bits    <= '0;
            count_q <= '0;
            strobe  <= 1'b0;
        end else begin
            strobe <= done;
            if (done) begin
                insert  <= v.insert;
                nbits   <= stuff_count_of(v.insert);
                bits    <= v.insert ? value : '0;
                count_q <= count;
            end
        end
    end

    assign err_set = done && v.over_max;
endmodule

// File: rtl/fp_error_flag.sv
module fp_error_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clear,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst) flag <= 1'b0;
        else     flag <= set || (flag && !clear);
    end
endmodule

// File: rtl/fp_stuff_unit.sv
module fp_stuff_unit
    import fp_stuff_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int SV_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gclk_tick,
    input  logic             pcm_sof,
    input  logic             hdsl_sof,
    input  logic [CNT_W-1:0] thr_nominal,
    input  logic [CNT_W-1:0] thr_maximum,
    input  logic [SV_W-1:0]  stuff_value,
    input  logic             err_clear,
    output logic             stuff_insert,
    output logic [2:0]       stuff_count,
    output logic [SV_W-1:0]  stuff_bits,
    output logic [CNT_W-1:0] phase_count,
    output logic             decision_strobe,
    output logic             stuff_err
);
    logic [CNT_W-1:0] live_cnt;
    logic             meas_done;
    logic [CNT_W-1:0] nom_q, max_q;
    logic             err_set;

    fp_phase_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .tick  (gclk_tick),
        .start (pcm_sof),
        .stop  (hdsl_sof),
        .count (live_cnt),
        .done  (meas_done)
    );

    fp_threshold_latch #(.CNT_W(CNT_W)) u_thr (
        .clk    (clk),
        .rst    (rst),
        .load   (pcm_sof),
        .nom_in (thr_nominal),
        .max_in (thr_maximum),
        .nom_q  (nom_q),
        .max_q  (max_q)
    );

    fp_decision #(.CNT_W(CNT_W), .SV_W(SV_W)) u_dec (
        .clk     (clk),
        .rst     (rst),
        .done    (meas_done),
        .count   (live_cnt),
        .nom_q   (nom_q),
        .max_q   (max_q),
        .value   (stuff_value),
        .insert  (stuff_insert),
        .nbits   (stuff_count),
        .bits    (stuff_bits),
        .count_q (phase_count),
        .strobe  (decision_strobe),
        .err_set (err_set)
    );

    fp_error_flag u_err (
        .clk   (clk),
        .rst   (rst),
        .set   (err_set),
        .clear (err_clear),
        .flag  (stuff_err)
    );
endmodule

// File: rtl/fp_stuff_unit_checker.sv
module fp_stuff_unit_checker #(
    parameter int CNT_W = 12,
    parameter int SV_W  = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             hdsl_sof,
    input logic             err_clear,
    input logic             stuff_insert,
    input logic [2:0]       stuff_count,
    input logic [SV_W-1:0]  stuff_bits,
    input logic [CNT_W-1:0] phase_count,
    input logic             decision_strobe,
    input logic             stuff_err
);
    assert_count_legal_R3: assert property (@(posedge clk) disable iff (rst)
        (stuff_count == 3'd0 || stuff_count == 3'd4));

    assert_strobe_timing_R6: assert property (@(posedge clk) disable iff (rst)
        decision_strobe |-> $past(hdsl_sof));

    assert_decision_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !hdsl_sof |=> ($stable(stuff_insert) && $stable(phase_count) && $stable(stuff_bits)));

    assert_err_rise_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(stuff_err) |-> $past(hdsl_sof));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (stuff_err && !err_clear) |=> stuff_err);

    assert_err_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (err_clear && !hdsl_sof) |=> !stuff_err);
endmodule

bind fp_stuff_unit fp_stuff_unit_checker #(.CNT_W(CNT_W), .SV_W(SV_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .hdsl_sof        (hdsl_sof),
    .err_clear       (err_clear),
    .stuff_insert    (stuff_insert),
    .stuff_count     (stuff_count),
    .stuff_bits      (stuff_bits),
    .phase_count     (phase_count),
    .decision_strobe (decision_strobe),
    .stuff_err       (stuff_err)
);

// File: tb/fp_stuff_unit_test.sv
module fp_stuff_unit_test;
    localparam int PERIOD = 10;
    localparam int CNT_W  = 12;
    localparam int SV_W   = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic gclk_tick = 1'b0, pcm_sof = 1'b0, hdsl_sof = 1'b0, err_clear = 1'b0;
    logic [CNT_W-1:0] thr_nominal = '0, thr_maximum = '0;
    logic [SV_W-1:0]  stuff_value = '0;
    logic             stuff_insert, decision_strobe, stuff_err;
    logic [2:0]       stuff_count;
    logic [SV_W-1:0]  stuff_bits;
    logic [CNT_W-1:0] phase_count;

    int compared = 0;
    int mismatched = 0;

    always #(PERIOD/2) clk = ~clk;

    fp_stuff_unit #(.CNT_W(CNT_W), .SV_W(SV_W)) uut (
        .clk(clk), .rst(rst), .gclk_tick(gclk_tick), .pcm_sof(pcm_sof),
        .hdsl_sof(hdsl_sof), .thr_nominal(thr_nominal), .thr_maximum(thr_maximum),
        .stuff_value(stuff_value), .err_clear(err_clear),
        .stuff_insert(stuff_insert), .stuff_count(stuff_count), .stuff_bits(stuff_bits),
        .phase_count(phase_count), .decision_strobe(decision_strobe), .stuff_err(stuff_err)
    );

    task automatic check(input string req, input int actual, input int expected);
        compared++;
        if (actual !== expected) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    // Start a measurement; clear pulse optional in the same cycle.
    task automatic start_meas(input int nom, input int mx, input bit clr);
        @(negedge clk);
        pcm_sof = 1'b1; thr_nominal = CNT_W'(nom); thr_maximum = CNT_W'(mx); err_clear = clr;
        @(negedge clk);
        pcm_sof = 1'b0; err_clear = 1'b0;
    endtask

    task automatic give_ticks(input int n, input bit gaps);
        for (int i = 0; i < n; i++) begin
            gclk_tick = 1'b1;
            @(negedge clk);
            gclk_tick = 1'b0;
            if (gaps) @(negedge clk);
        end
    endtask

    // hdsl_sof cycle, then sample at the following falling edge.
    task automatic end_meas(input int sv, input bit clr);
        hdsl_sof = 1'b1; stuff_value = SV_W'(sv); err_clear = clr;
        gclk_tick = 1'b1; // tick in the stop cycle is not counted (R2)
        @(negedge clk);
        hdsl_sof = 1'b0; err_clear = 1'b0; gclk_tick = 1'b0;
    endtask

    task automatic expect_result(input string tag, input int cnt, input int nom, input int mx, input int sv);
        int ins = (cnt < nom) ? 1 : 0;
        check({tag, " R6 strobe"}, int'(decision_strobe), 1);
        check({tag, " R2 count"}, int'(phase_count), cnt);
        check({tag, " R4 insert"}, int'(stuff_insert), ins);
        check({tag, " R3 count bits"}, int'(stuff_count), ins ? 4 : 0);
        check({tag, " R5 bits"}, int'(stuff_bits), ins ? sv : 0);
        check({tag, " R7 err"}, int'(stuff_err), (cnt >= mx) ? 1 : 0);
    endtask

    initial begin
        #(PERIOD * 200000);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 insert", int'(stuff_insert), 0);
        check("R1 count", int'(stuff_count), 0);
        check("R1 bits", int'(stuff_bits), 0);
        check("R1 phase", int'(phase_count), 0);
        check("R1 strobe", int'(decision_strobe), 0);
        check("R1 err", int'(stuff_err), 0);

        // Sweep: R2 R3 R4 R5 R7
        for (int nom = 0; nom < 6; nom++)
            for (int mx = 0; mx < 7; mx++)
                for (int t = 0; t < 8; t++) begin
                    int sv = (t * 3 + nom + mx) % 16;
                    start_meas(nom, mx, 1'b1);
                    give_ticks(t, t[0]);
                    end_meas(sv, 1'b0);
                    expect_result("sweep", t, nom, mx, sv);
                    @(negedge clk);
                    check("R6 strobe drop", int'(decision_strobe), 0);
                    check("R6 hold", int'(phase_count), t);
                end

        // R6: hdsl_sof with no measurement changes nothing
        start_meas(5, 9, 1'b1);
        give_ticks(2, 1'b0);
        end_meas(7, 1'b0);
        expect_result("base", 2, 5, 9, 7);
        hdsl_sof = 1'b1; stuff_value = 4'hC;
        @(negedge clk);
        hdsl_sof = 1'b0;
        check("R6 idle sof strobe", int'(decision_strobe), 0);
        check("R6 idle sof bits", int'(stuff_bits), 7);
        check("R6 idle sof insert", int'(stuff_insert), 1);

        // R10: mid-measurement threshold change ignored
        start_meas(2, 3, 1'b1);
        thr_nominal = 12'd100; thr_maximum = 12'd100;
        give_ticks(4, 1'b0);
        end_meas(9, 1'b0);
        expect_result("R10 thr", 4, 2, 3, 9);

        // R8: sticky over idle cycles
        repeat (5) @(negedge clk);
        check("R8 sticky", int'(stuff_err), 1);
        // R9: clear alone
        err_clear = 1'b1;
        @(negedge clk);
        err_clear = 1'b0;
        check("R9 clear", int'(stuff_err), 0);
        // R9: clear with new error keeps flag
        start_meas(1, 1, 1'b0);
        give_ticks(3, 1'b0);
        end_meas(2, 1'b1);
        check("R9 clear+set", int'(stuff_err), 1);

        // R11: restart
        start_meas(10, 20, 1'b1);
        give_ticks(5, 1'b0);
        start_meas(10, 20, 1'b0);
        give_ticks(2, 1'b1);
        end_meas(3, 1'b0);
        expect_result("R11 restart", 2, 10, 20, 3);

        // R11: stop and restart in one cycle
        start_meas(4, 8, 1'b1);
        give_ticks(3, 1'b0);
        hdsl_sof = 1'b1; pcm_sof = 1'b1; thr_nominal = 12'd1; thr_maximum = 12'd2; stuff_value = 4'h5;
        @(negedge clk);
        hdsl_sof = 1'b0; pcm_sof = 1'b0;
        expect_result("R11 same", 3, 4, 8, 5);
        give_ticks(1, 1'b0);
        end_meas(6, 1'b0);
        expect_result("R11 second", 1, 1, 2, 6);

        // R2 saturation
        start_meas(4095, 4095, 1'b1);
        give_ticks(4100, 1'b0);
        end_meas(1, 1'b0);
        expect_result("R2 sat", 4095, 4095, 4095, 1);

        summary();
        $finish;
    end
endmodule